// File: doc/BRIEF.md
# Driver Channel Fault Supervisor

This block sits between the control registers of a multi-channel power driver and its gate drivers. It decides, every clock, which gates are on. Each channel has a register enable. Each channel can also be driven by one of two shared PWM pins, chosen by a per-channel select bit. The first few channels are half-bridges. They have a second, low-side request, and dead time is inserted whenever the conduction changes side.

Three digital comparator flags come back from the analog side of each channel: overcurrent, short-circuit and open-load. Each flag is qualified by its own clock-cycle delay counter. A sustained overcurrent or short-circuit switches the channel off and latches an overload flag. The channel then stays off until software clears that flag. A sustained open load while the high side conducts latches an open-load flag but leaves the channel running. A supply fault input forces every gate off and latches a supply flag. A clear strobe drops only those flags whose fault input is quiet in that cycle.

Top module: `drv_fault_sup`

## Requirements
- R1: For a channel with no latched overload and no supply fault, `gate_hi[i]` equals `ctl_en[i] | (sel_p1[i] & pwm1) | (sel_p2[i] & pwm2)` as sampled at the previous clock edge. Half-bridge channels are also subject to R9.
- R2: If `cmp_ovl[i]` is high while channel i conducts (either gate) for `SD_DLY` consecutive clock edges, `ovl_flag[i]` is set and the channel's gates go off at that same edge.
- R3: If `cmp_sc[i]` is high while channel i conducts for `SC_DLY` consecutive clock edges, the result is the same as in R2.
- R4: While `ovl_flag[i]` is set, both gates of channel i stay off whatever the requests are. They can return only at the edge after the flag has cleared.
- R5: `cmp_opl[i]` counts only while `gate_hi[i]` is on. After `OL_DLY` consecutive such edges `opl_flag[i]` is set, and the gate is not switched off by it.
- R6: A qualification counter restarts from zero whenever its qualifying condition is absent at an edge, so a fault that pauses for one cycle never trips.
- R7: `supply_fault` high at an edge turns every gate off at that edge and sets `psf_flag`.
- R8: Flags stay set until a `clr` edge. That edge clears `ovl_flag[i]` only if `cmp_ovl[i]` and `cmp_sc[i]` are both low, clears `opl_flag[i]` only if `cmp_opl[i]` is low, and clears `psf_flag` only if `supply_fault` is low.
- R9: A half-bridge channel (index below `N_HB`) drives `gate_lo[i]` for `ctl_lo[i]` when no high-side request is present; the high side wins. Its two gates are never on together. After one side turns off, both stay off for at least `DEAD+1` cycles before the other side turns on.
- R10: While `rst_n` is low at a clock edge, all gate outputs and all flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_en | input | N_CH | Register enable, one bit per channel |
| ctl_lo | input | N_HB | Low-side request of the half-bridge channels |
| sel_p1 | input | N_CH | Channel follows pwm1 when set |
| sel_p2 | input | N_CH | Channel follows pwm2 when set |
| pwm1 | input | 1 | Direct PWM input 1 |
| pwm2 | input | 1 | Direct PWM input 2 |
| cmp_ovl | input | N_CH | Overcurrent comparator per channel |
| cmp_sc | input | N_CH | Short-circuit comparator per channel |
| cmp_opl | input | N_CH | Open-load comparator per channel |
| supply_fault | input | 1 | Supply out of range |
| clr | input | 1 | Flag clear strobe |
| gate_hi | output | N_CH | High-side gate enables |
| gate_lo | output | N_HB | Low-side gate enables |
| ovl_flag | output | N_CH | Latched overload shutdown flags |
| opl_flag | output | N_CH | Latched open-load flags |
| psf_flag | output | 1 | Latched supply fault flag |

## Verification
The bench builds the block with four channels, two of them half-bridges, `SD_DLY=6`, `SC_DLY=2`, `OL_DLY=5` and `DEAD=2`. With delays this short, random comparator runs of a few cycles trip the filters often. Short dropouts in those runs also restart the counters (R6). The clear strobe therefore meets latched flags with their conditions both present and absent. Two half-bridges next to two plain channels exercise both generate variants. A dead time of two makes the off gap long enough that an off-by-one in the gap is visible.

// File: rtl/sup_pkg.sv
// Package: shared helpers for the fault supervisor.
// Assumes delays are at least 1.
package sup_pkg;

    // Width of a counter that must hold values 0 .. d-1.
    function automatic int cnt_w(input int d);
        return (d <= 2) ? 1 : $clog2(d);
    endfunction

endpackage

// File: rtl/fault_qual.sv
// Module: fault_qual
// Purpose: consecutive-cycle qualifier. hit is high at the DLY-th
// consecutive edge on which cond is high, and stays high while cond
// stays high. Any cycle with cond low restarts the count.
// Assumes DLY >= 1.
module fault_qual #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int W = sup_pkg::cnt_w(DLY);
    localparam logic [W-1:0] LAST = W'(DLY - 1);

    logic [W-1:0] run;

    assign hit = cond && (run == LAST);

    // Count consecutive qualifying cycles, saturating at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (!cond)      run <= '0;
        else if (run != LAST) run <= run + 1'b1;
    end
endmodule

// File: rtl/chan_faults.sv
// Module: chan_faults
// Purpose: per-channel fault qualification and latched flags.
// The overload flag is set by a qualified overcurrent or short circuit
// while the channel conducts. The open-load flag is set by a qualified
// open load while the high side conducts. clr drops a flag only when
// its raw condition is absent in that cycle.
// Assumes on_any/on_hi come from registered gates.
module chan_faults #(
    parameter int SD_DLY = 8,
    parameter int SC_DLY = 2,
    parameter int OL_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic c_ovl,
    input  logic c_sc,
    input  logic c_opl,
    input  logic on_any,
    input  logic on_hi,
    input  logic clr,
    output logic trip,
    output logic ovl_flag,
    output logic opl_flag
);
    logic hit_sd, hit_sc, hit_ol;

    fault_qual #(.DLY(SD_DLY)) u_sd (
        .clk(clk), .rst_n(rst_n), .cond(c_ovl && on_any), .hit(hit_sd));
    fault_qual #(.DLY(SC_DLY)) u_sc (
        .clk(clk), .rst_n(rst_n), .cond(c_sc && on_any), .hit(hit_sc));
    fault_qual #(.DLY(OL_DLY)) u_ol (
        .clk(clk), .rst_n(rst_n), .cond(c_opl && on_hi), .hit(hit_ol));

    assign trip = hit_sd || hit_sc;

    // Latch overload flag; a clear works only when both inputs are quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) ovl_flag <= 1'b0;
        else        ovl_flag <= trip || (ovl_flag && !(clr && !c_ovl && !c_sc));
    end

    // Latch open-load flag; a clear works only when the input is quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) opl_flag <= 1'b0;
        else        opl_flag <= hit_ol || (opl_flag && !(clr && !c_opl));
    end
endmodule

// File: rtl/hb_gate.sv
// Module: hb_gate
// Purpose: high/low gate pair of one half-bridge with dead time.
// A side may turn on only when both gates have been off long enough
// for the gap counter to reach zero. A side already on stays on while
// it is wanted. Assumes want_hi and want_lo are never both high.
module hb_gate #(
    parameter int DEAD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic want_lo,
    output logic g_hi,
    output logic g_lo
);
    localparam int DW = sup_pkg::cnt_w(DEAD + 1);
    localparam logic [DW-1:0] GAP = DW'(DEAD);

    logic [DW-1:0] gap;
    logic          free;

    assign free = (gap == '0);

    // Reload the gap while any side conducts, count it down when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            gap <= '0;
        else if (g_hi || g_lo) gap <= GAP;
        else if (!free)        gap <= gap - 1'b1;
    end

    // Gate registers: hold while wanted, start only from a free idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_hi <= 1'b0;
            g_lo <= 1'b0;
        end else begin
            g_hi <= want_hi && (g_hi || (!g_lo && free));
            g_lo <= want_lo && (g_lo || (!g_hi && free));
        end
    end
endmodule

// File: rtl/drv_fault_sup.sv
// Module: drv_fault_sup (top)
// Purpose: per-channel gate control with PWM routing, overload
// shutdown, open-load detection and supply-fault blanking.
// Channels 0..N_HB-1 are half-bridges with a low side; the rest are
// single high-side switches. Assumes 1 <= N_HB <= N_CH and all
// inputs synchronous to clk.
module drv_fault_sup #(
    parameter int N_CH   = 6,
    parameter int N_HB   = 3,
    parameter int SD_DLY = 200,
    parameter int SC_DLY = 16,
    parameter int OL_DLY = 400,
    parameter int DEAD   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] ctl_en,
    input  logic [N_HB-1:0] ctl_lo,
    input  logic [N_CH-1:0] sel_p1,
    input  logic [N_CH-1:0] sel_p2,
    input  logic            pwm1,
    input  logic            pwm2,
    input  logic [N_CH-1:0] cmp_ovl,
    input  logic [N_CH-1:0] cmp_sc,
    input  logic [N_CH-1:0] cmp_opl,
    input  logic            supply_fault,
    input  logic            clr,
    output logic [N_CH-1:0] gate_hi,
    output logic [N_HB-1:0] gate_lo,
    output logic [N_CH-1:0] ovl_flag,
    output logic [N_CH-1:0] opl_flag,
    output logic            psf_flag
);
    logic [N_CH-1:0] req;
    logic [N_CH-1:0] trip;
    logic [N_CH-1:0] blocked;

    assign req     = ctl_en | (sel_p1 & {N_CH{pwm1}}) | (sel_p2 & {N_CH{pwm2}});
    assign blocked = ovl_flag | trip | {N_CH{supply_fault}};

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic on_any;
        logic hi_q;

        chan_faults #(.SD_DLY(SD_DLY), .SC_DLY(SC_DLY), .OL_DLY(OL_DLY)) u_flt (
            .clk(clk), .rst_n(rst_n),
            .c_ovl(cmp_ovl[ch]), .c_sc(cmp_sc[ch]), .c_opl(cmp_opl[ch]),
            .on_any(on_any), .on_hi(hi_q), .clr(clr),
            .trip(trip[ch]), .ovl_flag(ovl_flag[ch]), .opl_flag(opl_flag[ch]));

        assign gate_hi[ch] = hi_q;

        if (ch < N_HB) begin : g_hb
            logic lo_q;

            hb_gate #(.DEAD(DEAD)) u_gate (
                .clk(clk), .rst_n(rst_n),
                .want_hi(req[ch] && !blocked[ch]),
                .want_lo(ctl_lo[ch] && !req[ch] && !blocked[ch]),
                .g_hi(hi_q), .g_lo(lo_q));

            assign gate_lo[ch] = lo_q;
            assign on_any      = hi_q || lo_q;
        end else begin : g_sw
            // Single switch: follow the request unless blocked.
            always_ff @(posedge clk) begin
                if (!rst_n) hi_q <= 1'b0;
                else        hi_q <= req[ch] && !blocked[ch];
            end

            assign on_any = hi_q;
        end
    end

    // Latch the supply fault; clear only when the supply is back.
    always_ff @(posedge clk) begin
        if (!rst_n) psf_flag <= 1'b0;
        else        psf_flag <= supply_fault || (psf_flag && !(clr && !supply_fault));
    end
endmodule

// File: rtl/drv_fault_sup_chk.sv
// Module: drv_fault_sup_chk
// Purpose: temporal properties of drv_fault_sup, attached by bind.
// Assumes reset is held low for at least two clock edges.
module drv_fault_sup_chk #(
    parameter int N_CH = 6,
    parameter int N_HB = 3,
    parameter int DEAD = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] cmp_opl,
    input logic            supply_fault,
    input logic            clr,
    input logic [N_CH-1:0] gate_hi,
    input logic [N_HB-1:0] gate_lo,
    input logic [N_CH-1:0] ovl_flag,
    input logic [N_CH-1:0] opl_flag,
    input logic            psf_flag
);
    localparam int RW = $clog2(DEAD + 2) + 1;
    localparam logic [RW-1:0] SAT = RW'(DEAD + 1);

    assert_psf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault |=> (psf_flag && gate_hi == '0 && gate_lo == '0));

    for (genvar i = 0; i < N_CH; i++) begin : g_all
        assert_ovl_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ovl_flag[i] |-> !gate_hi[i]);
        assert_ovl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ovl_flag[i] && !clr) |=> ovl_flag[i]);
        assert_opl_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(opl_flag[i]) |-> $past(gate_hi[i]));
        assert_opl_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (opl_flag[i] && cmp_opl[i]) |=> opl_flag[i]);
    end

    for (genvar h = 0; h < N_HB; h++) begin : g_hb
        logic [RW-1:0] off_lo, off_hi;

        // Cycles since each side was last seen on, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_lo <= SAT;
                off_hi <= SAT;
            end else begin
                if (gate_lo[h])        off_lo <= '0;
                else if (off_lo < SAT) off_lo <= off_lo + 1'b1;
                if (gate_hi[h])        off_hi <= '0;
                else if (off_hi < SAT) off_hi <= off_hi + 1'b1;
            end
        end

        assert_hb_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[h] && gate_lo[h]));
        assert_hi_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[h]) |-> (off_lo >= SAT));
        assert_lo_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[h]) |-> (off_hi >= SAT));
        assert_lo_ovl_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ovl_flag[h] |-> !gate_lo[h]);
    end
endmodule

bind drv_fault_sup drv_fault_sup_chk #(.N_CH(N_CH), .N_HB(N_HB), .DEAD(DEAD)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmp_opl(cmp_opl), .supply_fault(supply_fault),
    .clr(clr), .gate_hi(gate_hi), .gate_lo(gate_lo), .ovl_flag(ovl_flag),
    .opl_flag(opl_flag), .psf_flag(psf_flag));

// File: tb/test_drv_fault_sup.sv
// Bench: directed corner cases, then seeded random stimulus, all
// compared each cycle against a cycle model written from the requirements.
module test_drv_fault_sup;
    localparam int N    = 4;
    localparam int NHB  = 2;
    localparam int SD   = 6;
    localparam int SC   = 2;
    localparam int OL   = 5;
    localparam int DT   = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0]   ctl_en, sel_p1, sel_p2, cmp_ovl, cmp_sc, cmp_opl;
    logic [NHB-1:0] ctl_lo;
    logic pwm1, pwm2, supply_fault, clr;
    logic [N-1:0]   gate_hi, ovl_flag, opl_flag;
    logic [NHB-1:0] gate_lo;
    logic psf_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    drv_fault_sup #(.N_CH(N), .N_HB(NHB), .SD_DLY(SD), .SC_DLY(SC),
                    .OL_DLY(OL), .DEAD(DT)) i_drv_fault_sup (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_lo(ctl_lo),
        .sel_p1(sel_p1), .sel_p2(sel_p2), .pwm1(pwm1), .pwm2(pwm2),
        .cmp_ovl(cmp_ovl), .cmp_sc(cmp_sc), .cmp_opl(cmp_opl),
        .supply_fault(supply_fault), .clr(clr), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .ovl_flag(ovl_flag), .opl_flag(opl_flag),
        .psf_flag(psf_flag));

    // ---------------- reference model ----------------
    logic [N-1:0]   m_hi, m_ovl, m_opl;
    logic [NHB-1:0] m_lo;
    logic           m_psf;
    int m_sd[N], m_sc[N], m_ol[N], m_gap[N];

    function automatic int q_next(input int run, input bit cond, input int dly);
        if (!cond) return 0;
        return (run < dly - 1) ? run + 1 : run;
    endfunction

    function automatic bit q_hit(input int run, input bit cond, input int dly);
        return cond && (run == dly - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_ovl = '0; m_opl = '0; m_psf = 1'b0;
            for (int i = 0; i < N; i++) begin
                m_sd[i] = 0; m_sc[i] = 0; m_ol[i] = 0; m_gap[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                bit lo, on, csd, csc, col, trip, blk, rq, wh, wl, nh, nl;
                lo   = (i < NHB) ? m_lo[i] : 1'b0;
                on   = m_hi[i] | lo;
                csd  = cmp_ovl[i] & on;
                csc  = cmp_sc[i] & on;
                col  = cmp_opl[i] & m_hi[i];
                trip = q_hit(m_sd[i], csd, SD) | q_hit(m_sc[i], csc, SC);
                blk  = m_ovl[i] | trip | supply_fault;
                rq   = ctl_en[i] | (sel_p1[i] & pwm1) | (sel_p2[i] & pwm2);
                wh   = rq & !blk;
                if (i < NHB) begin
                    wl = ctl_lo[i] & !rq & !blk;
                    nh = wh & (m_hi[i] | (!lo & (m_gap[i] == 0)));
                    nl = wl & (lo | (!m_hi[i] & (m_gap[i] == 0)));
                    m_gap[i] = on ? DT : ((m_gap[i] > 0) ? m_gap[i] - 1 : 0);
                    m_lo[i] = nl;
                end else begin
                    nh = wh;
                end
                m_opl[i] = q_hit(m_ol[i], col, OL) | (m_opl[i] & !(clr & !cmp_opl[i]));
                m_ovl[i] = trip | (m_ovl[i] & !(clr & !cmp_ovl[i] & !cmp_sc[i]));
                m_sd[i] = q_next(m_sd[i], csd, SD);
                m_sc[i] = q_next(m_sc[i], csc, SC);
                m_ol[i] = q_next(m_ol[i], col, OL);
                m_hi[i] = nh;
            end
            m_psf = supply_fault | (m_psf & !(clr & !supply_fault));
        end
    end

    // ---------------- checking ----------------
    task automatic fail(input string tag, input int act, input int exp);
        n_bad++;
        $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    endtask

    task automatic expect_v(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) fail(tag, act, exp);
    endtask

    // Compare every output against the model; each field names its requirement.
    task automatic cmp_model();
        n_vec++;
        if (gate_hi  !== m_hi)  fail("R1 gate_hi",  int'(gate_hi),  int'(m_hi));
        if (gate_lo  !== m_lo)  fail("R9 gate_lo",  int'(gate_lo),  int'(m_lo));
        if (ovl_flag !== m_ovl) fail("R2 ovl_flag", int'(ovl_flag), int'(m_ovl));
        if (opl_flag !== m_opl) fail("R5 opl_flag", int'(opl_flag), int'(m_opl));
        if (psf_flag !== m_psf) fail("R7 psf_flag", int'(psf_flag), int'(m_psf));
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            cmp_model();
        end
    endtask

    function automatic logic [N-1:0] flip(input logic [N-1:0] v, input int pct);
        for (int b = 0; b < N; b++)
            if ($urandom_range(99) < pct) v[b] = ~v[b];
        return v;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fail("watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [N-1:0] tmp;
        seed = $urandom(32'd4711);
        rst_n = 1'b0; ctl_en = '0; ctl_lo = '0; sel_p1 = '0; sel_p2 = '0;
        pwm1 = 1'b0; pwm2 = 1'b0; cmp_ovl = '0; cmp_sc = '0; cmp_opl = '0;
        supply_fault = 1'b0; clr = 1'b0;
        @(negedge clk);
        ctl_en = '1; cmp_opl = '1;   // reset must win over requests
        tick(3);
        expect_v("R10 reset gates", int'({gate_hi, gate_lo}), 0);
        expect_v("R10 reset flags", int'({ovl_flag, opl_flag, psf_flag}), 0);
        ctl_en = '0; cmp_opl = '0; rst_n = 1'b1;
        tick(1);

        // R1: PWM routing on channel 3.
        sel_p2[3] = 1'b1; pwm2 = 1'b1; tick(1);
        expect_v("R1 pwm2 routed", int'(gate_hi[3]), 1);
        pwm2 = 1'b0; tick(1);
        expect_v("R1 pwm2 low", int'(gate_hi[3]), 0);
        sel_p2[3] = 1'b0;

        // R3: short circuit trips after SC cycles.
        ctl_en[2] = 1'b1; tick(1);
        expect_v("R1 reg enable", int'(gate_hi[2]), 1);
        cmp_sc[2] = 1'b1; tick(SC - 1);
        expect_v("R3 before delay", int'(ovl_flag[2]), 0);
        tick(1);
        expect_v("R3 flag", int'(ovl_flag[2]), 1);
        expect_v("R3 gate off", int'(gate_hi[2]), 0);

        // R4/R8: stays off; clear blocked while condition present.
        clr = 1'b1; tick(1); clr = 1'b0;
        expect_v("R8 clear refused", int'(ovl_flag[2]), 1);
        cmp_sc[2] = 1'b0; tick(3);
        expect_v("R4 held off", int'(gate_hi[2]), 0);
        clr = 1'b1; tick(1); clr = 1'b0;
        expect_v("R8 cleared", int'(ovl_flag[2]), 0);
        expect_v("R4 off at clear edge", int'(gate_hi[2]), 0);
        tick(1);
        expect_v("R4 back on", int'(gate_hi[2]), 1);

        // R6: a one-cycle gap restarts the overload count; then R2 trips.
        cmp_ovl[2] = 1'b1; tick(SD - 1);
        cmp_ovl[2] = 1'b0; tick(1);
        cmp_ovl[2] = 1'b1; tick(SD - 1);
        expect_v("R6 restart", int'(ovl_flag[2]), 0);
        tick(1);
        expect_v("R2 flag", int'(ovl_flag[2]), 1);
        expect_v("R2 gate off", int'(gate_hi[2]), 0);
        cmp_ovl[2] = 1'b0; clr = 1'b1; tick(1); clr = 1'b0; tick(1);

        // R5: open load only with gate on; flag does not stop the gate.
        cmp_opl[3] = 1'b1; tick(OL + 2);
        expect_v("R5 ignored while off", int'(opl_flag[3]), 0);
        ctl_en[3] = 1'b1; tick(1 + OL);
        expect_v("R5 flag", int'(opl_flag[3]), 1);
        expect_v("R5 gate stays", int'(gate_hi[3]), 1);
        clr = 1'b1; tick(1);
        expect_v("R8 opl kept", int'(opl_flag[3]), 1);
        cmp_opl[3] = 1'b0; tick(1); clr = 1'b0;
        expect_v("R8 opl cleared", int'(opl_flag[3]), 0);

        // R9: low side, then high side wins with dead time.
        ctl_lo[0] = 1'b1; tick(1);
        expect_v("R9 low on", int'(gate_lo[0]), 1);
        ctl_en[0] = 1'b1; tick(DT + 1);
        expect_v("R9 gap both off", int'({gate_hi[0], gate_lo[0]}), 0);
        tick(1);
        expect_v("R9 high after gap", int'(gate_hi[0]), 1);

        // R7: supply fault blanks everything.
        supply_fault = 1'b1; tick(1);
        expect_v("R7 gates off", int'({gate_hi, gate_lo}), 0);
        expect_v("R7 flag", int'(psf_flag), 1);
        supply_fault = 1'b0; clr = 1'b1; tick(1); clr = 1'b0;
        expect_v("R8 psf cleared", int'(psf_flag), 0);

        // Random phase.
        for (int c = 0; c < 4000; c++) begin
            ctl_en  = flip(ctl_en, 10);
            tmp     = flip(N'(ctl_lo), 10); ctl_lo = tmp[NHB-1:0];
            sel_p1  = flip(sel_p1, 5);
            sel_p2  = flip(sel_p2, 5);
            cmp_ovl = flip(cmp_ovl, 12);
            cmp_sc  = flip(cmp_sc, 15);
            cmp_opl = flip(cmp_opl, 12);
            if ($urandom_range(99) < 30) pwm1 = ~pwm1;
            if ($urandom_range(99) < 20) pwm2 = ~pwm2;
            if (supply_fault) supply_fault = ($urandom_range(99) >= 30);
            else              supply_fault = ($urandom_range(99) < 1);
            clr = ($urandom_range(99) < 6);
            tick(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule